// File: doc/BRIEF.md
# Dual-Mode Oversample Tick Generator

This block makes the 16x oversampling strobe that paces a serial transmitter and receiver. A 16-bit rate value sets the strobe rate, and a mode input chooses how that value is used. In integer divide mode the value is a reload count. The generator pulses once every `rate` clock cycles, so the value to program is the input clock divided by sixteen times the bit rate.

In phase-accumulate mode the value is an increment added to a 16-bit accumulator on every cycle. A strobe is produced each time the addition carries out of the top bit. The value to program is the bit rate times sixteen times 2^16, divided by the input clock. This mode gives fine rate resolution and is the preferred choice above about 19200 baud.

A run input gates the whole generator. Dropping run stops the strobe and clears both engines, so that generation always restarts from a known phase. Dropping run is also how the port is put into its idle, low-power state.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and afterwards for as long as `run_en` is 0, `tick` is 0.
- R2: In divide mode (`accum_mode`=0) with a rate N of 2 or more, the first `tick` is high in the cycle that follows the first clock edge at which `run_en` is 1. Further ticks follow every N cycles, and each tick lasts one cycle.
- R3: In divide mode, a rate of 0 or 1 gives `tick` high on every cycle while running.
- R4: In divide mode, a rate change made while running has no effect on the interval that is in progress. The new rate sets the interval that starts at the next tick.
- R5: In accumulate mode (`accum_mode`=1), the accumulator starts at 0 and adds `rate_val` modulo 2^16 at every edge. `tick` is high in the cycle after each edge whose addition carried out of bit 15.
- R6: In accumulate mode, a changed increment is used from the very next edge. An increment of 0 gives no tick.
- R7: Once `run_en` has been sampled 0, `tick` is 0 from the next cycle on. On restart, the divide engine and the accumulator begin again from phase zero.
- R8: Only the engine chosen by `accum_mode` is active, and the other engine is held cleared. After a switch into divide mode, the first tick comes one cycle after the first edge in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables generation; 0 stops and clears both engines |
| accum_mode | input | 1 | 0 = integer divide, 1 = phase accumulate |
| rate_val | input | 16 | Reload count or phase increment |
| tick | output | 1 | Single-cycle 16x oversample strobe |

## Verification
Every result shows up on `tick` exactly one cycle after the edge that samples the inputs producing it. The only register on the path is the output flop, which sits after the engine state.

The bench drives the inputs at the falling edge and computes the expected strobe for the coming rising edge. It pushes that value into a queue. A monitor pops the queue 2 ns after that rising edge and compares, so every cycle is checked at the one point where its result is due.

The divide model predicts the cycle index of the next strobe. The accumulate model keeps a wide running sum of increments and watches bit 16 change.

// File: rtl/btg_pkg.sv
package btg_pkg;

  // Value loaded into the down-counter when it expires.
  // 0 and 1 both mean "expire every cycle".
  function automatic logic [31:0] next_reload(input logic [31:0] rate);
    return (rate <= 32'd1) ? 32'd0 : rate - 32'd1;
  endfunction

  // One accumulate step; bit 'w' of the result is the carry out of a w-bit sum.
  function automatic logic [32:0] acc_step(input logic [31:0] acc,
                                           input logic [31:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

endpackage

// File: rtl/btg_divider.sv
module btg_divider #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  output logic              hit
);
  import btg_pkg::*;

  logic [RATE_W-1:0] cnt_q;
  logic [31:0]       rate_ext;
  logic [31:0]       reload;

  assign rate_ext = 32'(rate);
  assign reload   = next_reload(rate_ext);
  assign hit      = enable && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!enable) cnt_q <= '0;
    else if (hit)     cnt_q <= reload[RATE_W-1:0];
    else              cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/btg_accum.sv
module btg_accum #(
  parameter int unsigned RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] incr,
  output logic              hit
);
  import btg_pkg::*;

  logic [RATE_W-1:0] acc_q;
  logic [32:0]       sum_w;

  assign sum_w = acc_step(32'(acc_q), 32'(incr));
  assign hit   = enable && sum_w[RATE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (!enable) acc_q <= '0;
    else              acc_q <= sum_w[RATE_W-1:0];
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned RATE_W    = 16,
  parameter bit          HAS_ACCUM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              accum_mode,
  input  logic [RATE_W-1:0] rate_val,
  output logic              tick
);
  logic div_en;
  logic acc_en;
  logic div_hit;
  logic acc_hit;
  logic tick_q;

  assign div_en = run_en && !(HAS_ACCUM && accum_mode);
  assign acc_en = run_en && HAS_ACCUM && accum_mode;

  btg_divider #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(div_en), .rate(rate_val), .hit(div_hit)
  );

  generate
    if (HAS_ACCUM) begin : g_acc
      btg_accum #(.RATE_W(RATE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .enable(acc_en), .incr(rate_val), .hit(acc_hit)
      );
    end else begin : g_no_acc
      assign acc_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= div_hit | acc_hit;
  end

  assign tick = tick_q;
endmodule

// File: rtl/btg_checks.sv
module btg_checks #(
  parameter int unsigned RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              accum_mode,
  input logic [RATE_W-1:0] rate_val,
  input logic              div_hit,
  input logic              acc_hit,
  input logic              tick
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !tick);

  assert_stop_on_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick);

  assert_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !accum_mode && rate_val <= 1) |=> tick);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_en && !accum_mode && rate_val >= 2 && $stable(rate_val)
     && $past(run_en && !accum_mode)) |=> !tick);

  assert_zero_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && accum_mode && rate_val == '0) |=> !tick);

  assert_one_engine_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({div_hit, acc_hit}));
endmodule

bind baud_tick_gen btg_checks #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .accum_mode(accum_mode),
  .rate_val(rate_val), .div_hit(div_hit), .acc_hit(acc_hit), .tick(tick)
);

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        accum_mode = 1'b0;
  logic [15:0] rate_val = 16'd0;
  logic        tick;

  int    n_checks = 0;
  int    n_fail   = 0;
  item_t sb_q[$];

  // model state
  longint cyc      = 0;
  longint div_next = 0;
  bit     div_live = 1'b0;
  longint acc_tot  = 0;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .accum_mode(accum_mode),
    .rate_val(rate_val), .tick(tick)
  );

  always #10 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick=%b expected %b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: each expected value belongs to the edge right after it was pushed
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(tick, it.exp, it.tag);
    end
  end

  // driver: called at a falling edge, predicts tick after the next rising edge
  task automatic step(input logic r, input logic m, input logic [15:0] v, input string tag);
    item_t  it;
    logic   e;
    longint old;
    run_en = r; accum_mode = m; rate_val = v;
    e = 1'b0;
    if (!r) begin
      div_live = 1'b0; acc_tot = 0;
    end else if (!m) begin
      acc_tot = 0;
      if (!div_live) begin div_live = 1'b1; div_next = cyc; end
      if (cyc == div_next) begin
        e = 1'b1;
        div_next = cyc + ((v <= 16'd1) ? 1 : longint'(v));
      end
    end else begin
      div_live = 1'b0;
      old = acc_tot;
      acc_tot = acc_tot + longint'(v);
      e = ((acc_tot >> 16) != (old >> 16));
    end
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    cyc++;
    @(negedge clk);
  endtask

  task automatic run_n(input int n, input logic r, input logic m,
                       input logic [15:0] v, input string tag);
    for (int i = 0; i < n; i++) step(r, m, v, tag);
  endtask

  // watchdog
  initial begin
    #2000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tick, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    run_n(4, 1'b0, 1'b0, 16'd5, "R1");
    // divide mode, period 5 (R2)
    run_n(26, 1'b1, 1'b0, 16'd5, "R2");
    // stop, restart from phase zero (R7)
    run_n(3, 1'b0, 1'b0, 16'd5, "R7");
    run_n(12, 1'b1, 1'b0, 16'd3, "R7 restart");
    // rate 1 and rate 0 (R3)
    run_n(6, 1'b1, 1'b0, 16'd1, "R3 rate1");
    run_n(6, 1'b1, 1'b0, 16'd0, "R3 rate0");
    // change 4 -> 7 mid interval (R4)
    run_n(6, 1'b1, 1'b0, 16'd4, "R4");
    run_n(20, 1'b1, 1'b0, 16'd7, "R4");
    // accumulate, exact quarter rate (R5)
    run_n(20, 1'b1, 1'b1, 16'h4000, "R5 quarter");
    // accumulate, fractional rate (R5)
    run_n(40, 1'b1, 1'b1, 16'h2AAB, "R5 fraction");
    // increment change and zero increment (R6)
    run_n(10, 1'b1, 1'b1, 16'hC000, "R6 change");
    run_n(10, 1'b1, 1'b1, 16'h0000, "R6 zero");
    // switch back to divide mode (R8)
    run_n(10, 1'b1, 1'b0, 16'd4, "R8 to divide");
    run_n(10, 1'b1, 1'b1, 16'h8000, "R8 to accum");
    // stop while in accumulate mode, then restart (R7)
    run_n(4, 1'b0, 1'b1, 16'h8000, "R7 stop accum");
    run_n(10, 1'b1, 1'b1, 16'h6000, "R7 accum restart");
    run_n(3, 1'b0, 1'b0, 16'd0, "R7 idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule